// File: doc/BRIEF.md
# Debug Mailbox Between Core and Test Clock Domains

This block lets a running processor core and an external debugger pass data words to each other without stopping the program. It has two independent queues, each carrying data one way only. The upstream queue takes words written by the core and hands them to the test side. The downstream queue takes words written by the test side and hands them to the core. The two sides run on unrelated clocks whose rates may differ by orders of magnitude. Each queue is a dual-clock FIFO, four entries deep by default, and exchanges Gray-coded pointers through two-flop synchronizers.

Each clock domain has a small side controller. It accepts a write only while its outgoing queue is not full. It accepts a read only while its incoming queue is not empty, and it returns the head word with a valid strobe on the next cycle. A write attempted into a full queue, or a read attempted from an empty one, is dropped and sets a sticky error flag in that domain. Each reset input is asynchronous and active low, and it is released synchronously inside its own domain.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both sides show an empty incoming queue, a not-full outgoing queue, valid low, and both sticky flags clear.
- R2: Words that the core writes arrive at the test side in write order, without loss or duplication.
- R3: Words that the test side writes arrive at the core in write order, without loss or duplication.
- R4: A read with rd_en high while the incoming queue is not empty raises rd_valid in the next cycle of that clock, with the head word on rd_data. Valid is low in any cycle not preceded by such a read.
- R5: The empty flag is high whenever the queue it describes holds no word.
- R6: After four writes with no reads, the writer's full flag is high. A further write is dropped, leaves the queue contents unchanged, and sets that side's sticky overflow flag until reset.
- R7: A read while the incoming queue is empty returns no valid strobe and sets that side's sticky underflow flag until reset.
- R8: Once the opposite side has been quiet for four cycles of the slower clock, full is high exactly when the queue holds four words, and empty is high exactly when it holds none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Core clock |
| cpu_rst_n | input | 1 | Core-side asynchronous active-low reset |
| cpu_wr_en | input | 1 | Core write request into the upstream queue |
| cpu_wr_data | input | DATA_W | Word written by the core |
| cpu_up_full | output | 1 | Upstream queue full, as seen by the core |
| cpu_ovf | output | 1 | Sticky flag: core wrote into a full queue |
| cpu_rd_en | input | 1 | Core read request from the downstream queue |
| cpu_rd_data | output | DATA_W | Word delivered to the core |
| cpu_rd_valid | output | 1 | cpu_rd_data valid this cycle |
| cpu_dn_empty | output | 1 | Downstream queue empty, as seen by the core |
| cpu_udf | output | 1 | Sticky flag: core read from an empty queue |
| tst_clk | input | 1 | Test clock |
| tst_rst_n | input | 1 | Test-side asynchronous active-low reset |
| tst_wr_en | input | 1 | Test-side write request into the downstream queue |
| tst_wr_data | input | DATA_W | Word written by the test side |
| tst_dn_full | output | 1 | Downstream queue full, as seen by the test side |
| tst_ovf | output | 1 | Sticky flag: test side wrote into a full queue |
| tst_rd_en | input | 1 | Test-side read request from the upstream queue |
| tst_rd_data | output | DATA_W | Word delivered to the test side |
| tst_rd_valid | output | 1 | tst_rd_data valid this cycle |
| tst_up_empty | output | 1 | Upstream queue empty, as seen by the test side |
| tst_udf | output | 1 | Sticky flag: test side read from an empty queue |

## Verification
A corrupted write pointer or memory slot shows up at the first read of the affected entry, as a word that is wrong or out of order on rd_data in the reading domain. A pointer that drifts in the other direction shows up as a full or empty flag that disagrees with the true occupancy once the other side has been quiet for four slow-clock cycles. A wrong synchronizer value or Gray conversion shows as empty released too early, so a read strobes valid on a slot that was never written, within a few cycles of the write. A broken side controller is visible at once: valid appears without an accepted read in the previous cycle, or a sticky flag fails to rise on the cycle after a dropped request.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  typedef enum logic {
    SIDE_IDLE = 1'b0,
    SIDE_DLVR = 1'b1
  } side_st_e;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded bus.
module mbx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mbx_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release.
module mbx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage  <= 1'b1;
      srst_n <= stage;
    end
  end
endmodule

// File: rtl/mbx_afifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with Gray pointers. DEPTH is a power of two, at least 4.
module mbx_afifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wbin_nxt, wgray, wgray_nxt;
  logic [PW-1:0] rbin, rbin_nxt, rgray, rgray_nxt;
  logic [PW-1:0] rgray_w, wgray_r;

  // write domain
  always_comb begin
    wbin_nxt  = wbin + {{(PW-1){1'b0}}, push};
    wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wdata;
  end

  mbx_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));

  assign full = (wgray == {~rgray_w[PW-1 -: 2], rgray_w[PW-3:0]});

  // read domain
  always_comb begin
    rbin_nxt  = rbin + {{(PW-1){1'b0}}, pop};
    rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_nxt;
      rgray <= rgray_nxt;
    end
  end

  mbx_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

  assign empty = (rgray == wgray_r);
  assign head  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/mbx_side.sv
`timescale 1ns/1ps
// Per-domain controller: gates requests against the flags, delivers words, keeps sticky errors.
module mbx_side
  import mbx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ovf,
  output logic          udf,
  output logic          push,
  output logic [DW-1:0] push_data,
  input  logic          tx_full,
  output logic          pop,
  input  logic [DW-1:0] rx_head,
  input  logic          rx_empty
);
  side_st_e st, st_nxt;
  logic     ovf_nxt, udf_nxt;

  assign push      = wr_en & ~tx_full;
  assign push_data = wr_data;
  assign pop       = rd_en & ~rx_empty;

  always_comb begin
    st_nxt  = pop ? SIDE_DLVR : SIDE_IDLE;
    ovf_nxt = ovf | (wr_en & tx_full);
    udf_nxt = udf | (rd_en & rx_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SIDE_IDLE;
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      st  <= st_nxt;
      ovf <= ovf_nxt;
      udf <= udf_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_data <= '0;
    else if (pop) rd_data <= rx_head;
  end

  assign rd_valid = (st == SIDE_DLVR);
endmodule

// File: rtl/dbg_mailbox.sv
`timescale 1ns/1ps
module dbg_mailbox #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              cpu_clk,
  input  logic              cpu_rst_n,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output logic              cpu_up_full,
  output logic              cpu_ovf,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic              cpu_rd_valid,
  output logic              cpu_dn_empty,
  output logic              cpu_udf,
  input  logic              tst_clk,
  input  logic              tst_rst_n,
  input  logic              tst_wr_en,
  input  logic [DATA_W-1:0] tst_wr_data,
  output logic              tst_dn_full,
  output logic              tst_ovf,
  input  logic              tst_rd_en,
  output logic [DATA_W-1:0] tst_rd_data,
  output logic              tst_rd_valid,
  output logic              tst_up_empty,
  output logic              tst_udf
);
  logic              cpu_rst_q, tst_rst_q;
  logic              up_push, up_pop, dn_push, dn_pop;
  logic [DATA_W-1:0] up_wdata, up_head, dn_wdata, dn_head;

  mbx_rst_sync u_cpu_rst (.clk(cpu_clk), .arst_n(cpu_rst_n), .srst_n(cpu_rst_q));
  mbx_rst_sync u_tst_rst (.clk(tst_clk), .arst_n(tst_rst_n), .srst_n(tst_rst_q));

  // upstream: core -> test side
  mbx_afifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_up (
    .wclk(cpu_clk), .wrst_n(cpu_rst_q), .push(up_push), .wdata(up_wdata), .full(cpu_up_full),
    .rclk(tst_clk), .rrst_n(tst_rst_q), .pop(up_pop), .head(up_head), .empty(tst_up_empty)
  );

  // downstream: test side -> core
  mbx_afifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_dn (
    .wclk(tst_clk), .wrst_n(tst_rst_q), .push(dn_push), .wdata(dn_wdata), .full(tst_dn_full),
    .rclk(cpu_clk), .rrst_n(cpu_rst_q), .pop(dn_pop), .head(dn_head), .empty(cpu_dn_empty)
  );

  mbx_side #(.DW(DATA_W)) u_cpu_side (
    .clk(cpu_clk), .rst_n(cpu_rst_q),
    .wr_en(cpu_wr_en), .wr_data(cpu_wr_data), .rd_en(cpu_rd_en),
    .rd_data(cpu_rd_data), .rd_valid(cpu_rd_valid), .ovf(cpu_ovf), .udf(cpu_udf),
    .push(up_push), .push_data(up_wdata), .tx_full(cpu_up_full),
    .pop(dn_pop), .rx_head(dn_head), .rx_empty(cpu_dn_empty)
  );

  mbx_side #(.DW(DATA_W)) u_tst_side (
    .clk(tst_clk), .rst_n(tst_rst_q),
    .wr_en(tst_wr_en), .wr_data(tst_wr_data), .rd_en(tst_rd_en),
    .rd_data(tst_rd_data), .rd_valid(tst_rd_valid), .ovf(tst_ovf), .udf(tst_udf),
    .push(dn_push), .push_data(dn_wdata), .tx_full(tst_dn_full),
    .pop(up_pop), .rx_head(up_head), .rx_empty(tst_up_empty)
  );
endmodule

// File: rtl/mbx_chk.sv
`timescale 1ns/1ps
module mbx_chk (
  input logic cpu_clk,
  input logic cpu_rst_n,
  input logic cpu_wr_en,
  input logic cpu_up_full,
  input logic cpu_ovf,
  input logic cpu_rd_en,
  input logic cpu_dn_empty,
  input logic cpu_rd_valid,
  input logic cpu_udf,
  input logic tst_clk,
  input logic tst_rst_n,
  input logic tst_wr_en,
  input logic tst_dn_full,
  input logic tst_ovf,
  input logic tst_rd_en,
  input logic tst_up_empty,
  input logic tst_rd_valid,
  input logic tst_udf
);
  // R4: valid only after an accepted read
  p_cpu_valid_r4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    cpu_rd_valid |-> $past(cpu_rd_en && !cpu_dn_empty));
  p_tst_valid_r4: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
    tst_rd_valid |-> $past(tst_rd_en && !tst_up_empty));

  // R6: dropped write raises overflow, which stays
  p_cpu_ovf_r6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (cpu_wr_en && cpu_up_full) |=> cpu_ovf);
  p_tst_ovf_r6: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
    (tst_wr_en && tst_dn_full) |=> tst_ovf);
  p_cpu_ovf_sticky_r6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    cpu_ovf |=> cpu_ovf);

  // R7: read on empty gives no valid and raises underflow
  p_cpu_udf_r7: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (cpu_rd_en && cpu_dn_empty) |=> (cpu_udf && !cpu_rd_valid));
  p_tst_udf_r7: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
    (tst_rd_en && tst_up_empty) |=> (tst_udf && !tst_rd_valid));
  p_tst_udf_sticky_r7: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
    tst_udf |=> tst_udf);
endmodule

bind dbg_mailbox mbx_chk u_chk (
  .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_q), .cpu_wr_en(cpu_wr_en), .cpu_up_full(cpu_up_full),
  .cpu_ovf(cpu_ovf), .cpu_rd_en(cpu_rd_en), .cpu_dn_empty(cpu_dn_empty),
  .cpu_rd_valid(cpu_rd_valid), .cpu_udf(cpu_udf),
  .tst_clk(tst_clk), .tst_rst_n(tst_rst_q), .tst_wr_en(tst_wr_en), .tst_dn_full(tst_dn_full),
  .tst_ovf(tst_ovf), .tst_rd_en(tst_rd_en), .tst_up_empty(tst_up_empty),
  .tst_rd_valid(tst_rd_valid), .tst_udf(tst_udf)
);

// File: tb/dbg_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_mailbox_tb;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic          cpu_clk = 1'b0, tst_clk = 1'b0;
  logic          cpu_rst_n = 1'b0, tst_rst_n = 1'b0;
  logic          cpu_wr_en = 1'b0, cpu_rd_en = 1'b0, tst_wr_en = 1'b0, tst_rd_en = 1'b0;
  logic [DW-1:0] cpu_wr_data = '0, tst_wr_data = '0;
  logic          cpu_up_full, cpu_ovf, cpu_rd_valid, cpu_dn_empty, cpu_udf;
  logic          tst_dn_full, tst_ovf, tst_rd_valid, tst_up_empty, tst_udf;
  logic [DW-1:0] cpu_rd_data, tst_rd_data;

  always #2.5  cpu_clk = ~cpu_clk;
  always #18.5 tst_clk = ~tst_clk;

  dbg_mailbox #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_up_full(cpu_up_full), .cpu_ovf(cpu_ovf), .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
    .cpu_rd_valid(cpu_rd_valid), .cpu_dn_empty(cpu_dn_empty), .cpu_udf(cpu_udf),
    .tst_clk(tst_clk), .tst_rst_n(tst_rst_n), .tst_wr_en(tst_wr_en), .tst_wr_data(tst_wr_data),
    .tst_dn_full(tst_dn_full), .tst_ovf(tst_ovf), .tst_rd_en(tst_rd_en), .tst_rd_data(tst_rd_data),
    .tst_rd_valid(tst_rd_valid), .tst_up_empty(tst_up_empty), .tst_udf(tst_udf)
  );

  int n_tests = 0, n_fail = 0;
  bit run = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] up_q[$], dn_q[$];
  bit            e_cpu_v = 0, e_tst_v = 0, e_cpu_ovf = 0, e_cpu_udf = 0, e_tst_ovf = 0, e_tst_udf = 0;
  logic [DW-1:0] e_cpu_d = '0, e_tst_d = '0;
  int            up_rx = 0, dn_rx = 0;

  always @(posedge cpu_clk) if (run) begin
    if (cpu_wr_en && !cpu_up_full) up_q.push_back(cpu_wr_data);
    if (cpu_wr_en && cpu_up_full) e_cpu_ovf = 1;
    e_cpu_v = 0;
    if (cpu_rd_en && !cpu_dn_empty) begin
      if (dn_q.size() == 0) chk(0, "R5 core read accepted with no word", 1, 0);
      else begin e_cpu_v = 1; e_cpu_d = dn_q.pop_front(); dn_rx++; end
    end
    if (cpu_rd_en && cpu_dn_empty) e_cpu_udf = 1;
  end

  always @(posedge tst_clk) if (run) begin
    if (tst_wr_en && !tst_dn_full) dn_q.push_back(tst_wr_data);
    if (tst_wr_en && tst_dn_full) e_tst_ovf = 1;
    e_tst_v = 0;
    if (tst_rd_en && !tst_up_empty) begin
      if (up_q.size() == 0) chk(0, "R5 test read accepted with no word", 1, 0);
      else begin e_tst_v = 1; e_tst_d = up_q.pop_front(); up_rx++; end
    end
    if (tst_rd_en && tst_up_empty) e_tst_udf = 1;
  end

  always @(negedge cpu_clk) if (run) begin
    chk(cpu_rd_valid == e_cpu_v, "R4 core valid", cpu_rd_valid, e_cpu_v);
    if (e_cpu_v) chk(cpu_rd_data == e_cpu_d, "R3 core data", cpu_rd_data, e_cpu_d);
    chk(cpu_ovf == e_cpu_ovf, "R6 core overflow", cpu_ovf, e_cpu_ovf);
    chk(cpu_udf == e_cpu_udf, "R7 core underflow", cpu_udf, e_cpu_udf);
    if (up_q.size() == DEPTH) chk(cpu_up_full, "R6 core full", cpu_up_full, 1);
    if (dn_q.size() == 0) chk(cpu_dn_empty, "R5 core empty", cpu_dn_empty, 1);
  end

  always @(negedge tst_clk) if (run) begin
    chk(tst_rd_valid == e_tst_v, "R4 test valid", tst_rd_valid, e_tst_v);
    if (e_tst_v) chk(tst_rd_data == e_tst_d, "R2 test data", tst_rd_data, e_tst_d);
    chk(tst_ovf == e_tst_ovf, "R6 test overflow", tst_ovf, e_tst_ovf);
    chk(tst_udf == e_tst_udf, "R7 test underflow", tst_udf, e_tst_udf);
    if (dn_q.size() == DEPTH) chk(tst_dn_full, "R6 test full", tst_dn_full, 1);
    if (up_q.size() == 0) chk(tst_up_empty, "R5 test empty", tst_up_empty, 1);
  end

  task automatic settle_check();
    repeat (4) @(negedge tst_clk);
    @(negedge cpu_clk);
    chk(cpu_up_full == (up_q.size() == DEPTH), "R8 core full settled", cpu_up_full, up_q.size());
    chk(cpu_dn_empty == (dn_q.size() == 0), "R8 core empty settled", cpu_dn_empty, dn_q.size());
    @(negedge tst_clk);
    chk(tst_dn_full == (dn_q.size() == DEPTH), "R8 test full settled", tst_dn_full, dn_q.size());
    chk(tst_up_empty == (up_q.size() == 0), "R8 test empty settled", tst_up_empty, up_q.size());
  endtask

  task automatic cpu_write(input logic [DW-1:0] d);
    @(negedge cpu_clk); cpu_wr_en = 1; cpu_wr_data = d;
    @(negedge cpu_clk); cpu_wr_en = 0;
  endtask

  task automatic tst_write(input logic [DW-1:0] d);
    @(negedge tst_clk); tst_wr_en = 1; tst_wr_data = d;
    @(negedge tst_clk); tst_wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge cpu_clk);
    chk(0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100;
    // R1 reset state
    chk(cpu_dn_empty == 1 && tst_up_empty == 1, "R1 empty in reset", {cpu_dn_empty, tst_up_empty}, 2'b11);
    chk(cpu_up_full == 0 && tst_dn_full == 0, "R1 full clear in reset", {cpu_up_full, tst_dn_full}, 0);
    chk({cpu_rd_valid, tst_rd_valid, cpu_ovf, cpu_udf, tst_ovf, tst_udf} == 0, "R1 strobes and flags clear",
        {cpu_rd_valid, tst_rd_valid, cpu_ovf, cpu_udf, tst_ovf, tst_udf}, 0);
    @(negedge cpu_clk) cpu_rst_n = 1;
    @(negedge tst_clk) tst_rst_n = 1;
    repeat (4) @(negedge tst_clk);
    run = 1;
    settle_check();

    // R2 R6: fill upstream, fifth write is dropped
    for (int i = 0; i < 5; i++) cpu_write(32'hA000_0000 + i);
    settle_check();
    // R2 R7: drain upstream with back-to-back reads, one extra read underflows
    @(negedge tst_clk) tst_rd_en = 1;
    repeat (5) @(negedge tst_clk);
    tst_rd_en = 0;
    settle_check();
    chk(up_rx == 4, "R6 dropped word never delivered", up_rx, 4);

    // R3 R7: three words downstream, four reads at the core
    for (int i = 0; i < 3; i++) tst_write(32'h5B00_0000 + i);
    settle_check();
    @(negedge cpu_clk) cpu_rd_en = 1;
    repeat (4) @(negedge cpu_clk);
    cpu_rd_en = 0;
    settle_check();
    chk(dn_rx == 3, "R3 core received count", dn_rx, 3);

    // R6 downstream full from the test side
    for (int i = 0; i < 5; i++) tst_write(32'hC0DE_0000 + i);
    settle_check();
    @(negedge cpu_clk) cpu_rd_en = 1;
    repeat (4) @(negedge cpu_clk);
    cpu_rd_en = 0;
    settle_check();

    // R2 R3: both directions concurrently with flow control
    fork
      begin
        for (int i = 0; i < 20; i++) begin
          @(negedge cpu_clk);
          while (cpu_up_full) @(negedge cpu_clk);
          cpu_wr_en = 1; cpu_wr_data = 32'h1234_0000 ^ (i * 32'h0101_0101);
          @(negedge cpu_clk); cpu_wr_en = 0;
        end
      end
      begin
        @(negedge tst_clk) tst_rd_en = 1;
        wait (up_rx >= 24);
        @(negedge tst_clk) tst_rd_en = 0;
      end
      begin
        for (int i = 0; i < 20; i++) begin
          @(negedge tst_clk);
          while (tst_dn_full) @(negedge tst_clk);
          tst_wr_en = 1; tst_wr_data = 32'hFEED_0000 + i * 7;
          @(negedge tst_clk); tst_wr_en = 0;
        end
      end
      begin
        @(negedge cpu_clk) cpu_rd_en = 1;
        wait (dn_rx >= 27);
        @(negedge cpu_clk) cpu_rd_en = 0;
      end
    join
    settle_check();
    chk(up_rx == 24, "R2 total delivered to test side", up_rx, 24);
    chk(dn_rx == 27, "R3 total delivered to core", dn_rx, 27);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule